// File: doc/BRIEF.md
# Coarse-Fine Interval Timer Combiner

This block measures the time between one start strobe and one stop strobe. It counts whole reference clock periods between the two strobes. It then adds the sub-period offset of each strobe, which external interpolators supply as codes. With a 4 ns reference clock and 5-bit fine codes, one result unit is 125 ps, or one thirty-second of a clock period.

The controller pulses `arm` to clear the previous measurement and prepare for a new one. The first accepted start latches its fine code and begins counting. The first stop after that start freezes the count. It then produces the result as the whole-period count times 2^FINE_W, plus the start code, minus the stop code. Only one start/stop pair is measured per arm. If no stop arrives before the counter reaches its top value, the block flags overflow and leaves the result invalid.

Top module: `tdc_combiner`

## Requirements
- R1: After reset, `result_valid`, `overflow` and `result` are all 0. Start and stop strobes have no effect until `arm` is pulsed.
- R2: A cycle with `arm` high clears `result` to 0 and clears `result_valid` and `overflow` on the following edge. It also makes the block ready to accept a start. While `arm` is high, start and stop are ignored.
- R3: The coarse count is the number of clock edges from the edge that samples the accepted start to the edge that samples the stop. A stop one cycle after the start gives a count of 1.
- R4: `result` equals coarse × 2^FINE_W + start_fine − stop_fine, as an unsigned (COARSE_W+FINE_W)-bit value. It appears with `result_valid` high right after the edge that samples the stop.
- R5: A stop that arrives while the block is armed but before any start is ignored.
- R6: A start that arrives while counting is ignored. The fine code of the first start is kept.
- R7: Once a result is valid, further start and stop strobes are ignored. `result` and `result_valid` hold until the next `arm`.
- R8: If the count equals 2^COARSE_W − 1 and no stop is sampled on that edge, `overflow` goes high and `result_valid` stays low until the next `arm`. A stop on that same edge still gives a valid result.
- R9: If start and stop are high in the same cycle while armed, the start is accepted and that stop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Clear the previous result and prepare for one measurement |
| start | input | 1 | Start strobe, sampled on the rising clock edge |
| start_fine | input | FINE_W | Interpolator code for the start offset |
| stop | input | 1 | Stop strobe, sampled on the rising clock edge |
| stop_fine | input | FINE_W | Interpolator code for the stop offset |
| result | output | COARSE_W+FINE_W | Combined interval in fine units |
| result_valid | output | 1 | Result is complete and held |
| overflow | output | 1 | Counter reached its top value without a stop |

## Verification
The bench builds the block with FINE_W = 5 and COARSE_W = 4. This keeps the full fine resolution but shrinks the coarse range to 15 periods. With that range, both the last valid count and the overflow edge take only a few cycles to reach. The bench sweeps every start/stop fine-code pair at two coarse counts, and it sweeps every coarse count up to the top value. The expected value is formed arithmetically from the requirement formula. Directed sequences cover stray stops, repeated starts, coincident strobes, hits after completion, hits before the first arm, and re-arming.

// File: rtl/tdc_combiner.sv
module tdc_combiner #(
  parameter int FINE_W   = 5,
  parameter int COARSE_W = 15
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       arm,
  input  logic                       start,
  input  logic [FINE_W-1:0]          start_fine,
  input  logic                       stop,
  input  logic [FINE_W-1:0]          stop_fine,
  output logic [COARSE_W+FINE_W-1:0] result,
  output logic                       result_valid,
  output logic                       overflow
);

  localparam int RES_W = COARSE_W + FINE_W;
  localparam logic [COARSE_W-1:0] CNT_TOP = '1;

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_RUN, S_DONE} st_t;

  st_t                st;
  logic [COARSE_W-1:0] cnt;
  logic [FINE_W-1:0]   sfine;
  logic [RES_W-1:0]    sum;

  assign sum = {cnt, {FINE_W{1'b0}}} + RES_W'(sfine) - RES_W'(stop_fine);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      cnt          <= '0;
      sfine        <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      overflow     <= 1'b0;
    end else if (arm) begin
      st           <= S_ARMED;
      cnt          <= '0;
      result       <= '0;
      result_valid <= 1'b0;
      overflow     <= 1'b0;
    end else begin
      case (st)
        S_ARMED: if (start) begin
          st    <= S_RUN;
          cnt   <= COARSE_W'(1);
          sfine <= start_fine;
        end
        S_RUN: begin
          if (stop) begin
            st           <= S_DONE;
            result       <= sum;
            result_valid <= 1'b1;
          end else if (cnt == CNT_TOP) begin
            st       <= S_DONE;
            overflow <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(result_valid && overflow));

  p_arm_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!result_valid && !overflow && result == '0));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (result_valid && !arm) |=> (result_valid && $stable(result)));

  p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !arm) |=> (overflow && !result_valid));

  p_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (result != '0));

  p_no_early_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ARMED && !arm) |=> !result_valid);

endmodule

// File: tb/tdc_combiner_tb_top.sv
`timescale 1ns/1ps
module tdc_combiner_tb_top;
  localparam int FW = 5;
  localparam int CW = 4;
  localparam int RW = FW + CW;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, start = 1'b0, stop = 1'b0;
  logic [FW-1:0] start_fine = '0, stop_fine = '0;
  logic [RW-1:0] result;
  logic result_valid, overflow;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tdc_combiner #(.FINE_W(FW), .COARSE_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .arm(arm), .start(start), .start_fine(start_fine),
    .stop(stop), .stop_fine(stop_fine), .result(result),
    .result_valid(result_valid), .overflow(overflow));

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic hit(input int j, input int sf, input int pf);
    start = 1'b1; start_fine = FW'(sf);
    @(negedge clk) start = 1'b0;
    repeat (j - 1) @(negedge clk);
    stop = 1'b1; stop_fine = FW'(pf);
    @(negedge clk) stop = 1'b0;
  endtask

  task automatic measure(input string req, input int j, input int sf, input int pf);
    do_arm();
    hit(j, sf, pf);
    check(req, {result_valid, overflow}, 2);
    check(req, int'(result), j * 32 + sf - pf);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset state", {result_valid, overflow, 9'b0} | int'(result), 0);
    hit(2, 5, 3);
    check("R1 hit before arm ignored", {result_valid, overflow}, 0);

    for (int sf = 0; sf < 32; sf++)
      for (int pf = 0; pf < 32; pf++) begin
        measure("R4 fine sweep j=1", 1, sf, pf);
        measure("R4 fine sweep j=15", 15, sf, pf);
      end
    for (int j = 1; j < 16; j++)
      measure("R3 coarse sweep", j, (j * 2) % 32, 31 - j);

    do_arm();
    check("R2 arm clears", {result_valid, overflow, 9'b0} | int'(result), 0);

    do_arm();
    stop = 1'b1; stop_fine = 5'd7;
    @(negedge clk) stop = 1'b0;
    check("R5 stray stop ignored", {result_valid, overflow}, 0);
    hit(2, 10, 4);
    check("R5 later measurement", int'(result), 70);

    do_arm();
    start = 1'b1; start_fine = 5'd3;
    @(negedge clk) start_fine = 5'd20;
    @(negedge clk) start = 1'b0;
    @(negedge clk) begin stop = 1'b1; stop_fine = 5'd5; end
    @(negedge clk) stop = 1'b0;
    check("R6 second start ignored", int'(result), 94);

    do_arm();
    start = 1'b1; start_fine = 5'd9; stop = 1'b1; stop_fine = 5'd1;
    @(negedge clk) begin start = 1'b0; stop = 1'b0; end
    check("R9 coincident stop ignored", {result_valid, overflow}, 0);
    @(negedge clk) begin stop = 1'b1; stop_fine = 5'd2; end
    @(negedge clk) stop = 1'b0;
    check("R9 start accepted", int'(result), 71);

    hit(3, 0, 0);
    hit(1, 31, 31);
    repeat (4) @(negedge clk);
    check("R7 result held", int'(result), 71);
    check("R7 valid held", {result_valid, overflow}, 2);
    do_arm();
    check("R2 re-arm clears", {result_valid, overflow, 9'b0} | int'(result), 0);

    do_arm();
    start = 1'b1; start_fine = 5'd4;
    @(negedge clk) start = 1'b0;
    repeat (14) @(negedge clk);
    check("R8 no overflow before top", {result_valid, overflow}, 0);
    @(negedge clk);
    check("R8 overflow at top", {result_valid, overflow}, 1);
    hit(2, 1, 1);
    check("R8 overflow holds", {result_valid, overflow}, 1);
    do_arm();
    check("R2 clears overflow", {result_valid, overflow}, 0);
    measure("R8 stop at top valid", 15, 0, 31);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule